// File: doc/BRIEF.md
# Prioritized Interrupt Vector Arbiter

This block sits beside an 8-bit processor core. It chooses which request the core serves next. It gathers three reset causes, a software-interrupt strobe, an external interrupt request and the status flags of three peripherals. Each peripheral flag comes with its own local enable. The block then presents one winner to the core: a valid flag, a source code and the 16-bit address of that source's vector.

Reset has the highest priority. The software interrupt comes next and is not affected by the global mask. After it, in order, come the external request, the timer, the serial port and the SPI port. All four of these are blocked while the global mask is set. Each peripheral request is formed by ORing its flag/enable pairs.

Once a choice has been shown to the core, it stays fixed until the core acknowledges it. Only a reset cause can replace it earlier. A software-interrupt strobe is remembered until the core acknowledges that interrupt.

Top module: `irq_vector_arb`

## Requirements
- R1: When any of the power-on, watchdog or pin reset causes is high, the outputs in that same cycle are valid, source code 1 and vector 16'h3FFE. This holds even while another choice is being held, and any held choice is dropped.
- R2: A software strobe gives source code 2 and vector 16'h3FFC in the same cycle, whatever the global mask is. If the strobe cannot be shown at once, it stays pending until the core acknowledges a source-2 output.
- R3: The external request gives source code 3 and vector 16'h3FFA.
- R4: The timer request is (capture flag AND its enable) OR (compare flag AND its enable) OR (overflow flag AND its enable). Flag bits [0], [1] and [2] are capture, compare and overflow, and each pairs with the enable bit of the same index. The timer gives source code 4 and vector 16'h3FF8. A flag whose enable is low raises no request.
- R5: The serial request is the OR of four pairs. Bit [0] is transmit-empty, bit [1] is transmit-complete, bit [2] is receive-full OR overrun, and bit [3] is idle. Each pairs with the enable bit of the same index. The serial port gives source code 5 and vector 16'h3FF6.
- R6: The SPI request is (transfer-done OR mode-fault) AND the single SPI enable. It gives source code 6 and vector 16'h3FF4.
- R7: While the global mask is 1, the external, timer, serial and SPI requests produce no new output.
- R8: Priority runs from highest to lowest as reset, software, external, timer, serial, SPI.
- R9: With no active request, the outputs are valid 0, source 0 and vector 0. This is also the state after reset is released with idle inputs.
- R10: Suppose the outputs are valid, the source is not reset, and acknowledge is low. Then the next cycle shows the same source and vector, whatever the inputs do, unless a reset cause is high.
- R11: Acknowledge releases the held choice at the next edge. Acknowledge while nothing is valid has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rst_por | input | 1 | Power-on reset cause |
| rst_wdog | input | 1 | Watchdog reset cause |
| rst_pin | input | 1 | Reset pin cause |
| swi_stb | input | 1 | Software interrupt strobe |
| ext_req | input | 1 | External interrupt request |
| gmask | input | 1 | Global mask for maskable sources |
| tmr_flags | input | 3 | Timer flags: capture, compare, overflow |
| tmr_en | input | 3 | Timer local enables |
| sci_flags | input | 4 | Serial flags: tx empty, tx complete, rx full, idle |
| sci_ovr | input | 1 | Serial overrun flag, shares the rx enable |
| sci_en | input | 4 | Serial local enables |
| spi_done | input | 1 | SPI transfer-done flag |
| spi_fault | input | 1 | SPI mode-fault flag |
| spi_en | input | 1 | SPI enable |
| cpu_ack | input | 1 | Core acknowledge of the presented choice |
| irq_valid | output | 1 | A choice is presented |
| irq_src | output | 3 | Source code 0..6 |
| irq_vector | output | 16 | Vector address of the source |

## Verification
Two things can happen in the same cycle: a new request with higher priority, and a choice already held for the core. This is provoked in two ways. One is to raise the software strobe, or a higher maskable source, while a lower source is held. The other is to fire a reset cause while a choice is held. The bench's model predicts each case: the held source must persist until acknowledge, the newcomer must appear right after, and reset must take over at once. A second collision is an acknowledge in the same cycle as a fresh software strobe. The model judges that case from the source shown in that cycle.

// File: rtl/irq_arb_pkg.sv
package irq_arb_pkg;
  localparam int SRC_W = 3;
  localparam int N_SRC = 6;

  typedef enum logic [SRC_W-1:0] {
    SRC_NONE = 3'd0,
    SRC_RST  = 3'd1,
    SRC_SWI  = 3'd2,
    SRC_EXT  = 3'd3,
    SRC_TMR  = 3'd4,
    SRC_SCI  = 3'd5,
    SRC_SPI  = 3'd6
  } src_e;
endpackage

// File: rtl/irq_pair_or.sv
module irq_pair_or #(
  parameter int N = 3
) (
  input  logic [N-1:0] flags,
  input  logic [N-1:0] enables,
  output logic         req
);
  logic [N-1:0] hit;

  generate
    for (genvar i = 0; i < N; i++) begin : g_pair
      assign hit[i] = flags[i] & enables[i];
    end
  endgenerate

  assign req = |hit;
endmodule

// File: rtl/irq_prio_enc.sv
module irq_prio_enc
  import irq_arb_pkg::*;
(
  input  logic [N_SRC:1] reqs,
  output src_e           win
);
  always_comb begin
    win = SRC_NONE;
    for (int i = N_SRC; i >= 1; i--) begin
      if (reqs[i]) win = src_e'(i);
    end
  end
endmodule

// File: rtl/irq_sel_hold.sv
module irq_sel_hold
  import irq_arb_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic rst_any,
  input  logic swi_stb,
  input  logic ack,
  input  src_e live_src,
  output logic swi_pend,
  output logic held_v,
  output src_e held_src,
  output src_e out_src
);
  logic swi_pend_n, held_v_n, upd_en;
  src_e held_src_n;

  always_comb begin
    if (rst_any)     out_src = SRC_RST;
    else if (held_v) out_src = held_src;
    else             out_src = live_src;
  end

  always_comb begin
    swi_pend_n = swi_pend;
    held_v_n   = held_v;
    held_src_n = held_src;
    if (rst_any) begin
      swi_pend_n = 1'b0;
      held_v_n   = 1'b0;
    end else begin
      swi_pend_n = swi_pend | swi_stb;
      if (ack && out_src == SRC_SWI) swi_pend_n = 1'b0;
      if (ack) begin
        held_v_n = 1'b0;
      end else if (!held_v && out_src != SRC_NONE) begin
        held_v_n   = 1'b1;
        held_src_n = out_src;
      end
    end
  end

  assign upd_en = (swi_pend_n != swi_pend) || (held_v_n != held_v) ||
                  (held_src_n != held_src);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      swi_pend <= 1'b0;
      held_v   <= 1'b0;
      held_src <= SRC_NONE;
    end else if (upd_en) begin
      swi_pend <= swi_pend_n;
      held_v   <= held_v_n;
      held_src <= held_src_n;
    end
  end
endmodule

// File: rtl/irq_vector_arb.sv
module irq_vector_arb
  import irq_arb_pkg::*;
#(
  parameter int          VEC_W   = 16,
  parameter logic [15:0] VEC_TOP = 16'h3FFE,
  parameter int          TMR_N   = 3,
  parameter int          SCI_N   = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             rst_por,
  input  logic             rst_wdog,
  input  logic             rst_pin,
  input  logic             swi_stb,
  input  logic             ext_req,
  input  logic             gmask,
  input  logic [TMR_N-1:0] tmr_flags,
  input  logic [TMR_N-1:0] tmr_en,
  input  logic [SCI_N-1:0] sci_flags,
  input  logic             sci_ovr,
  input  logic [SCI_N-1:0] sci_en,
  input  logic             spi_done,
  input  logic             spi_fault,
  input  logic             spi_en,
  input  logic             cpu_ack,
  output logic             irq_valid,
  output logic [SRC_W-1:0] irq_src,
  output logic [VEC_W-1:0] irq_vector
);
  localparam int RX_BIT = 2;

  // reset released synchronously
  logic [1:0] rst_sync;
  logic       rst_n_s;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync <= 2'b00;
    else        rst_sync <= {rst_sync[0], 1'b1};
  end
  assign rst_n_s = rst_sync[1];

  logic             rst_any, tmr_req, sci_req, spi_req, swi_act, swi_pend, held_v;
  logic [SCI_N-1:0] sci_flags_m;
  logic [N_SRC:1]   reqs;
  src_e             live_src, held_src, out_src;

  assign rst_any = rst_por | rst_wdog | rst_pin;

  always_comb begin
    sci_flags_m         = sci_flags;
    sci_flags_m[RX_BIT] = sci_flags[RX_BIT] | sci_ovr;
  end

  irq_pair_or #(.N(TMR_N)) u_tmr (.flags(tmr_flags), .enables(tmr_en), .req(tmr_req));
  irq_pair_or #(.N(SCI_N)) u_sci (.flags(sci_flags_m), .enables(sci_en), .req(sci_req));
  irq_pair_or #(.N(1))     u_spi (.flags(spi_done | spi_fault), .enables(spi_en), .req(spi_req));

  assign swi_act = swi_stb | swi_pend;

  always_comb begin
    reqs          = '0;
    reqs[SRC_RST] = rst_any;
    reqs[SRC_SWI] = swi_act;
    reqs[SRC_EXT] = ext_req & ~gmask;
    reqs[SRC_TMR] = tmr_req & ~gmask;
    reqs[SRC_SCI] = sci_req & ~gmask;
    reqs[SRC_SPI] = spi_req & ~gmask;
  end

  irq_prio_enc u_enc (.reqs(reqs), .win(live_src));

  irq_sel_hold u_hold (
    .clk(clk), .rst_n(rst_n_s), .rst_any(rst_any), .swi_stb(swi_stb),
    .ack(cpu_ack), .live_src(live_src), .swi_pend(swi_pend),
    .held_v(held_v), .held_src(held_src), .out_src(out_src)
  );

  logic [VEC_W-1:0] step;
  assign step       = VEC_W'(out_src - 3'd1) << 1;
  assign irq_valid  = (out_src != SRC_NONE);
  assign irq_src    = out_src;
  assign irq_vector = irq_valid ? (VEC_TOP - step) : '0;
endmodule

// File: rtl/irq_vector_arb_chk.sv
module irq_vector_arb_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        rst_por,
  input logic        rst_wdog,
  input logic        rst_pin,
  input logic        swi_stb,
  input logic        ext_req,
  input logic        gmask,
  input logic        cpu_ack,
  input logic        irq_valid,
  input logic [2:0]  irq_src,
  input logic [15:0] irq_vector
);
  logic rst_c;
  assign rst_c = rst_por | rst_wdog | rst_pin;

  // R1
  reset_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rst_c |-> (irq_valid && irq_src == 3'd1 && irq_vector == 16'h3FFE));

  // R2
  swi_seen_chk: assert property (@(posedge clk) disable iff (!rst_n)
    swi_stb |-> irq_valid);

  // R3
  ext_seen_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ext_req && !gmask) |-> irq_valid);

  // R9
  idle_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !irq_valid |-> (irq_src == 3'd0 && irq_vector == 16'h0000));

  // R10
  hold_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_valid && !cpu_ack && irq_src != 3'd1) |=> (rst_c || $stable(irq_src)));
endmodule

bind irq_vector_arb irq_vector_arb_chk u_chk (
  .clk(clk), .rst_n(rst_n), .rst_por(rst_por), .rst_wdog(rst_wdog),
  .rst_pin(rst_pin), .swi_stb(swi_stb), .ext_req(ext_req), .gmask(gmask),
  .cpu_ack(cpu_ack), .irq_valid(irq_valid), .irq_src(irq_src),
  .irq_vector(irq_vector)
);

// File: tb/irq_vector_arb_test.sv
module irq_vector_arb_test;
  logic clk = 1'b0;
  logic rst_n;
  logic rst_por, rst_wdog, rst_pin, swi_stb, ext_req, gmask;
  logic [2:0] tmr_flags, tmr_en;
  logic [3:0] sci_flags, sci_en;
  logic sci_ovr, spi_done, spi_fault, spi_en, cpu_ack;
  logic irq_valid;
  logic [2:0] irq_src;
  logic [15:0] irq_vector;

  int n_tests = 0, n_fail = 0;
  bit m_held = 0, m_pend = 0;
  int m_src = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  irq_vector_arb uut (.*);

  function automatic int model_src();
    if (rst_por || rst_wdog || rst_pin) return 1;
    if (m_held) return m_src;
    if (swi_stb || m_pend) return 2;
    if (!gmask) begin
      if (ext_req) return 3;
      if (|(tmr_flags & tmr_en)) return 4;
      if (|({sci_flags[3], sci_flags[2] | sci_ovr, sci_flags[1:0]} & sci_en)) return 5;
      if ((spi_done || spi_fault) && spi_en) return 6;
    end
    return 0;
  endfunction

  task automatic idle();
    {rst_por, rst_wdog, rst_pin, swi_stb, ext_req, gmask, sci_ovr,
     spi_done, spi_fault, spi_en, cpu_ack} = '0;
    tmr_flags = '0; tmr_en = '0; sci_flags = '0; sci_en = '0;
  endtask

  // compare now, then advance the model over one clock edge
  task automatic step(input string tag);
    int e;
    int ev;
    #1;
    e  = model_src();
    ev = (e == 0) ? 0 : (16'h3FFE - 2 * (e - 1));
    n_tests++;
    if (irq_valid !== (e != 0) || irq_src !== 3'(e) || irq_vector !== 16'(ev)) begin
      n_fail++;
      $display("FAIL %s: valid=%0b src=%0d vec=%h expected valid=%0b src=%0d vec=%h",
               tag, irq_valid, irq_src, irq_vector, e != 0, e, 16'(ev));
    end
    @(posedge clk);
    if (rst_por || rst_wdog || rst_pin) begin
      m_held = 0; m_pend = 0;
    end else begin
      m_pend = m_pend | swi_stb;
      if (cpu_ack && e == 2) m_pend = 0;
      if (cpu_ack) m_held = 0;
      else if (!m_held && e != 0) begin m_held = 1; m_src = e; end
    end
    @(negedge clk);
  endtask

  task automatic ack_once(input string tag);
    cpu_ack = 1; step(tag); cpu_ack = 0;
  endtask

  initial begin
    #400000;
    n_fail++;
    $display("FAIL watchdog: valid=%0b src=%0d expected run to finish", irq_valid, irq_src);
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    idle();
    rst_n = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    repeat (3) @(negedge clk);
    step("R9 reset state");
    step("R9 idle");

    // R1 each cause
    rst_por = 1; step("R1 por"); rst_por = 0;
    rst_wdog = 1; step("R1 wdog"); rst_wdog = 0;
    rst_pin = 1; ext_req = 1; swi_stb = 1; step("R1 pin over all, R8"); idle();
    step("R9 after reset cause");

    // R2 swi with mask set, then pending until ack
    gmask = 1; swi_stb = 1; step("R2 swi masked"); swi_stb = 0;
    step("R2 swi held"); ack_once("R2 swi ack"); step("R11 swi gone"); gmask = 0;

    // R3
    ext_req = 1; step("R3 ext"); ack_once("R11 ack ext"); ext_req = 0; step("R9");

    // R4 each timer pair, and flag without enable
    for (int i = 0; i < 3; i++) begin
      tmr_flags = 3'(1 << i); tmr_en = 3'(1 << i);
      step("R4 timer pair"); ack_once("R4 ack"); idle(); step("R4 cleared");
    end
    tmr_flags = 3'b111; tmr_en = 3'b000; step("R4 no enable"); idle();

    // R5 serial pairs incl overrun
    for (int i = 0; i < 4; i++) begin
      sci_flags = 4'(1 << i); sci_en = 4'(1 << i);
      step("R5 serial pair"); ack_once("R5 ack"); idle(); step("R5 cleared");
    end
    sci_ovr = 1; sci_en = 4'b0100; step("R5 overrun"); ack_once("R5 ack"); idle();
    sci_ovr = 1; sci_en = 4'b1011; step("R5 overrun wrong enable"); idle();

    // R6
    spi_fault = 1; spi_en = 1; step("R6 fault"); ack_once("R6 ack"); idle();
    spi_done = 1; step("R6 done no enable"); idle();

    // R7 mask blocks all maskables
    gmask = 1; ext_req = 1; tmr_flags = 3'b1; tmr_en = 3'b1; spi_done = 1; spi_en = 1;
    step("R7 masked"); step("R7 masked 2"); idle();

    // R8 + R10: spi held, then higher sources appear
    spi_done = 1; spi_en = 1; step("R10 spi shown");
    ext_req = 1; swi_stb = 1; step("R10 spi held vs swi/ext"); swi_stb = 0;
    step("R10 still held"); ack_once("R10 ack spi");
    step("R8 swi first"); ack_once("R8 ack swi");
    step("R8 ext next"); ack_once("R8 ack ext"); idle();
    // reset during hold
    ext_req = 1; step("R10 ext"); ext_req = 0; rst_pin = 1; step("R1 preempt hold");
    rst_pin = 0; step("R1 hold dropped");
    // ack with nothing valid
    ack_once("R11 ack idle"); step("R11 idle after ack");

    // random traffic, model compared each cycle
    for (int k = 0; k < 3000; k++) begin
      idle();
      rst_por   = ($urandom_range(0, 60) == 0);
      swi_stb   = ($urandom_range(0, 15) == 0);
      ext_req   = ($urandom_range(0, 5) == 0);
      gmask     = ($urandom_range(0, 3) == 0);
      tmr_flags = 3'($urandom); tmr_en = 3'($urandom_range(0, 7) & 3'($urandom));
      sci_flags = 4'($urandom); sci_en = 4'($urandom) & 4'($urandom);
      sci_ovr   = 1'($urandom);
      spi_done  = 1'($urandom); spi_fault = 1'($urandom); spi_en = 1'($urandom);
      cpu_ack   = ($urandom_range(0, 2) == 0);
      step("R8 R10 R11 random");
    end
    idle();
    step("R9 final");
    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule